// File: doc/BRIEF.md
# One-Wire Device Select Sequencer

This block addresses a single slave on a one-wire bus so that a function command can follow. A controller pulses `start` with a mode and the number of slaves known to be on the bus. The sequencer asks the bus master engine for a reset pulse first. If no slave answers with a presence pulse, it stops there and reports an error. If a slave does answer, it sends the addressing bytes one at a time through the engine's byte-write port.

The addressing bytes depend on the mode and the slave count. In select mode, a bus with exactly one slave gets the skip-ROM byte. Any other count gets match-ROM followed by the 64-bit device ID. In resume mode, the resume byte is sent when more than one slave may be present, and skip-ROM is sent otherwise. Bit timing, search and CRC checking belong to other blocks.

Both request channels use a level request with a one-cycle acknowledge. `bus_reset_req` or `byte_req` stays high until the engine pulses the matching acknowledge. The presence result is read in the same cycle as `bus_reset_ack`.

Top module: `owire_select_seq`

## Requirements
- R1: After reset, `done`, `error`, `bus_reset_req` and `byte_req` are all low.
- R2: A `start` seen in the idle state raises `bus_reset_req` on the next cycle. It stays high until `bus_reset_ack` and is never high together with `byte_req`.
- R3: If `bus_presence` is low when `bus_reset_ack` is sampled, `done` and `error` are both high on the next cycle and no byte is requested.
- R4: In select mode (`resume_mode`=0) with `slave_count`=1, exactly one byte is sent, value 0xCC.
- R5: In select mode with `slave_count` greater than 1, nine bytes are sent: 0x55 followed by `rom_id[7:0]`, `rom_id[15:8]` and so on up to `rom_id[63:56]`.
- R6: In resume mode (`resume_mode`=1), exactly one byte is sent: 0xA5 when `slave_count` is not 1, and 0xCC when it is 1.
- R7: A `slave_count` of 0 is treated as the multi-slave case: match-ROM with the ID in select mode, and resume in resume mode.
- R8: While `byte_req` waits for `byte_ack`, `byte_data` is held stable. Each `byte_ack` accounts for exactly one byte, and the next byte is offered only after that acknowledge.
- R9: On success, `done` pulses high for one cycle, on the cycle after the last byte's acknowledge, with `error` low. `error` is never high without `done`.
- R10: `start` pulses during a running sequence are ignored. `resume_mode`, `slave_count` and `rom_id` are captured at start, so changing them mid-sequence alters no byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a select sequence (taken only when idle) |
| resume_mode | input | 1 | 0 = select by ROM, 1 = resume |
| slave_count | input | CNT_W | Number of slaves known on the bus |
| rom_id | input | 8*ID_BYTES | Device ID, low byte sent first |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Valid with done: no presence detected |
| bus_reset_req | output | 1 | Request a bus reset pulse |
| bus_reset_ack | input | 1 | Reset pulse finished, presence valid |
| bus_presence | input | 1 | Presence pulse seen during the reset |
| byte_req | output | 1 | Request to write byte_data |
| byte_data | output | 8 | Byte to write |
| byte_ack | input | 1 | Byte write finished |

## Verification
The bound checker checks the request handshakes on every cycle:
- a reset request never overlaps a byte request;
- a request and its byte stay put until acknowledged;
- `done` lasts one cycle and `error` never appears without it;
- a missing presence is always followed by an error completion.

Which bytes are sent, how many, and in what order can only be shown by the bench's scenarios. The bench sweeps both modes, every slave count of a small counter, presence and absence, and varied acknowledge latency. It also covers a restart attempt made mid-sequence while the inputs change.

// File: rtl/owire_select_seq.sv
module owire_select_seq #(
  parameter int CNT_W    = 4,
  parameter int ID_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  resume_mode,
  input  logic [CNT_W-1:0]      slave_count,
  input  logic [8*ID_BYTES-1:0] rom_id,
  output logic                  done,
  output logic                  error,
  output logic                  bus_reset_req,
  input  logic                  bus_reset_ack,
  input  logic                  bus_presence,
  output logic                  byte_req,
  output logic [7:0]            byte_data,
  input  logic                  byte_ack
);
  localparam int IW = $clog2(ID_BYTES + 1);
  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_RESUME = 8'hA5;

  typedef enum logic [1:0] {S_IDLE, S_RST, S_BYTE} state_t;

  state_t                state;
  logic [IW-1:0]         idx;
  logic                  resume_r, multi_r;
  logic [8*ID_BYTES-1:0] id_r;
  logic [7:0]            cmd;
  logic [IW-1:0]         last;

  assign cmd  = !multi_r ? CMD_SKIP : (resume_r ? CMD_RESUME : CMD_MATCH);
  assign last = (multi_r && !resume_r) ? IW'(ID_BYTES) : '0;

  assign bus_reset_req = (state == S_RST);
  assign byte_req      = (state == S_BYTE);
  assign byte_data     = (idx == '0) ? cmd : id_r[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      resume_r <= 1'b0;
      multi_r  <= 1'b0;
      id_r     <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          resume_r <= resume_mode;
          multi_r  <= (slave_count != CNT_W'(1));
          id_r     <= rom_id;
          idx      <= '0;
          state    <= S_RST;
        end
        S_RST: if (bus_reset_ack) begin
          if (bus_presence) begin
            state <= S_BYTE;
          end else begin
            done  <= 1'b1;
            error <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_BYTE: if (byte_ack) begin
          if (idx != '0) id_r <= id_r >> 8;
          if (idx == last) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owire_select_seq_chk.sv
module owire_select_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       error,
  input logic       bus_reset_req,
  input logic       bus_reset_ack,
  input logic       bus_presence,
  input logic       byte_req,
  input logic [7:0] byte_data,
  input logic       byte_ack
);
  // R2
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_reset_req && byte_req));

  // R2
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_req && !bus_reset_ack) |=> bus_reset_req);

  // R3
  no_presence_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_req && bus_reset_ack && !bus_presence) |=> (done && error && !byte_req));

  // R8
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && !byte_ack) |=> (byte_req && $stable(byte_data)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
endmodule

bind owire_select_seq owire_select_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .done(done), .error(error),
  .bus_reset_req(bus_reset_req), .bus_reset_ack(bus_reset_ack),
  .bus_presence(bus_presence), .byte_req(byte_req),
  .byte_data(byte_data), .byte_ack(byte_ack)
);

// File: tb/tb_owire_select_seq.sv
module tb_owire_select_seq;
  localparam int CNT_W = 4;
  localparam int NB    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          resume_mode = 1'b0;
  logic [CNT_W-1:0] slave_count = '0;
  logic [8*NB-1:0]  rom_id = '0;
  logic          done, error, bus_reset_req, byte_req;
  logic [7:0]    byte_data;
  logic          bus_reset_ack = 1'b0, bus_presence = 1'b0, byte_ack = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  owire_select_seq #(.CNT_W(CNT_W), .ID_BYTES(NB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .resume_mode(resume_mode),
    .slave_count(slave_count), .rom_id(rom_id), .done(done), .error(error),
    .bus_reset_req(bus_reset_req), .bus_reset_ack(bus_reset_ack),
    .bus_presence(bus_presence), .byte_req(byte_req), .byte_data(byte_data),
    .byte_ack(byte_ack)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input bit mode, input int cnt, input bit pres,
                     input logic [63:0] id, input int dly, input bit busy_start);
    logic [7:0] got [0:15];
    int  nbytes = 0;
    int  nresets = 0;
    bit  got_done = 0;
    bit  got_err = 0;
    bit  overlap = 0;
    bit  unstable = 0;
    bit  multi = (cnt != 1);
    int  exp_n = pres ? ((!mode && multi) ? 9 : 1) : 0;
    logic [7:0] exp_b;
    @(negedge clk);
    resume_mode = mode; slave_count = CNT_W'(cnt); rom_id = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(bus_reset_req && !byte_req, "R2", bus_reset_req, 1);
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (cyc != 0) @(negedge clk);
      bus_reset_ack = 1'b0; byte_ack = 1'b0;
      if (done) begin got_done = 1; got_err = error; break; end
      if (bus_reset_req && byte_req) overlap = 1;
      if (bus_reset_req) begin
        nresets++;
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          if (!bus_reset_req) overlap = 1;
        end
        bus_presence = pres; bus_reset_ack = 1'b1;
      end else if (byte_req) begin
        logic [7:0] d = byte_data;
        if (busy_start && nbytes == 2) begin
          start = 1'b1; rom_id = ~id; slave_count = CNT_W'(1); resume_mode = ~mode;
        end
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          start = 1'b0;
          if (byte_data !== d || !byte_req) unstable = 1;
        end
        if (nbytes < 16) got[nbytes] = d;
        nbytes++;
        byte_ack = 1'b1;
      end
    end
    check(got_done, "R9", got_done, 1);
    check(nresets == 1 && !overlap, "R2", nresets, 1);
    check(!unstable, "R8", unstable, 0);
    if (!pres) begin
      check(got_err && nbytes == 0, "R3", {got_err, nbytes[7:0]}, 9'h100);
    end else begin
      check(!got_err, "R9", got_err, 0);
      check(nbytes == exp_n, busy_start ? "R10" : (mode ? "R6" : (multi ? "R5" : "R4")), nbytes, exp_n);
      for (int i = 0; i < exp_n && i < nbytes; i++) begin
        if (i == 0) exp_b = !multi ? 8'hCC : (mode ? 8'hA5 : 8'h55);
        else        exp_b = 8'((id >> (8*(i-1))) & 64'hFF);
        check(got[i] == exp_b, cnt == 0 ? "R7" : (busy_start ? "R10" : (i == 0 ? (mode ? "R6" : "R4") : "R5")),
              got[i], exp_b);
      end
    end
    @(negedge clk);
    check(!done && !byte_req && !bus_reset_req, "R9", {done, byte_req, bus_reset_req}, 0);
    @(negedge clk);
    check(!bus_reset_req, "R10", bus_reset_req, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !error && !bus_reset_req && !byte_req, "R1",
          {done, error, bus_reset_req, byte_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !error && !bus_reset_req && !byte_req, "R1",
          {done, error, bus_reset_req, byte_req}, 0);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < (1 << CNT_W); c++)
        for (int p = 0; p < 2; p++)
          run(m[0], c, p[0], 64'h0123_4567_89AB_CDEF ^ (64'h1111_1111_1111_1111 * c) ^ {63'd0, m[0]},
              (c + p) % 3, 1'b0);
    run(1'b0, 3, 1'b1, 64'hF0E1_D2C3_B4A5_9687, 2, 1'b1);
    run(1'b0, 0, 1'b1, 64'h8877_6655_4433_2211, 1, 1'b1);
    run(1'b1, 5, 1'b1, 64'h1, 1, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule